// File: doc/BRIEF.md
# Nonvolatile Byte Array Program/Erase Controller

This block holds a 512-byte nonvolatile-style storage array that sits on a CPU byte bus. A single control register next to it sequences erase and program operations. Software first sets an arm bit. It then performs an ordinary bus write into the array window. That write does not change the array; it only captures the target address and, for a program, the data byte. Software then sets a go bit. A busy counter stands in for the long physical program time. When the counter expires with go still set, the operation is committed to the array.

Erase drives bytes to 0xFF at one of three granularities: a single byte, a 16-byte row, or the whole array. Programming can only clear bits, because the stored value becomes the old value ANDed with the new byte. An interlock refuses to set go unless arm was already set. While armed, the array leaves the bus map. A per-row lock vector from a separate protection block can suppress an operation, and an enable input can remove the array from the map entirely.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: The control register is read and written at address 0x103B and resets to 0x00. Its bit positions are: bit0 go, bit1 arm, bit2 erase, bit3 row select, bit4 byte select, bit5 always reads 0, and bits 7..6 are test bits.
- R2: go can become 1 only if arm or go was already 1 before the register write. A write that sets arm and go while both are 0 leaves both at 0. A write with go = 1 keeps go at 1 when it was already 1.
- R3: An erase sets the affected bytes to 0xFF and no other bytes. With byte select = 1 it clears one byte, whatever row select holds. With byte select = 0 and row select = 1 it clears the 16-byte row holding the captured address. With both at 0 it clears all 512 bytes.
- R4: The array occupies addresses 0xB600–0xB7FF, and row n spans 0xB600+16n to 0xB60F+16n. A read outside that window and outside the register returns rvalid = 0.
- R5: While arm = 1, an array read returns rvalid = 0. A bus write into the window only captures the address and data and never changes the array by itself.
- R6: A program stores old AND new at the captured byte, so a 0 bit never returns to 1.
- R7: In program mode (erase = 0) the row select and byte select bits are ignored, and exactly one byte changes.
- R8: With array_en_i = 0, array reads return rvalid = 0 and array writes are not captured. The control register stays accessible.
- R9: An operation commits only after PROG_CYCLES cycles of go = 1. Clearing go earlier aborts it with no change to the array.
- R10: If row_lock_i has a bit set for any row the operation touches, the array is left unchanged. A bulk erase touches every row.
- R11: With go = 1 and arm = 0 (read or undefined function), no array byte changes, and array reads return valid data.
- R12: The test bits are stored and read back but do not change how operations behave.
- R13: A read returns rdata and rvalid in the cycle after the one in which bus_rd is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Bus byte address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid for the previous cycle's read |
| array_en_i | input | 1 | 1 = array present in the map |
| row_lock_i | input | ROWS | Per-row protection, 1 = operations on that row suppressed |

## Verification
The bench keeps the array geometry at its default of 32 rows of 16 bytes. It shortens PROG_CYCLES to 16, so every byte can be programmed individually and a full 512-address readback sweep can be run after each erase mode. This also makes a bulk erase, which sweeps 512 cycles internally, cheap enough to repeat. The exhaustive sweeps show that a row or byte erase leaves every neighbouring byte untouched, and that an aborted, locked or disabled operation changes nothing anywhere in the array.

// File: rtl/nvm_pkg.sv
`timescale 1ns/1ps
package nvm_pkg;
  localparam int CTL_GO    = 0;
  localparam int CTL_ARM   = 1;
  localparam int CTL_ERASE = 2;
  localparam int CTL_ROW   = 3;
  localparam int CTL_BYTE  = 4;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_RD,
    ENG_WR,
    ENG_ERS
  } eng_st_t;

  typedef struct packed {
    logic sel_byte;
    logic sel_row;
    logic erase;
  } op_mode_t;
endpackage

// File: rtl/nvm_ctl_reg.sv
`timescale 1ns/1ps
module nvm_ctl_reg
  import nvm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] ctl_q
);
  logic was_idle;
  assign was_idle = ~ctl_q[CTL_ARM] & ~ctl_q[CTL_GO];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr_en) begin
      ctl_q[7:2]     <= {wdata[7:6], 1'b0, wdata[4:2]};
      ctl_q[CTL_ARM] <= wdata[CTL_ARM] & ~(wdata[CTL_GO] & was_idle);
      ctl_q[CTL_GO]  <= wdata[CTL_GO] & ~was_idle;
    end
  end
endmodule

// File: rtl/nvm_busy_timer.sv
`timescale 1ns/1ps
module nvm_busy_timer #(
  parameter int unsigned CYCLES = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic go,
  output logic fire
);
  localparam int CW = $clog2(CYCLES + 1);

  logic          run;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      cnt  <= '0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (!run) begin
        if (start) begin
          run <= 1'b1;
          cnt <= CW'(CYCLES);
        end
      end else if (!go) begin
        run <= 1'b0;
      end else if (cnt <= CW'(1)) begin
        run  <= 1'b0;
        fire <= 1'b1;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/nvm_array_engine.sv
`timescale 1ns/1ps
module nvm_array_engine
  import nvm_pkg::*;
#(
  parameter int ROWS      = 32,
  parameter int ROW_BYTES = 16
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     commit,
  input  op_mode_t                                 mode,
  input  logic [$clog2(ROWS*ROW_BYTES)-1:0]        tgt_addr,
  input  logic [7:0]                               tgt_data,
  input  logic [ROWS-1:0]                          row_lock,
  input  logic [$clog2(ROWS*ROW_BYTES)-1:0]        rd_addr,
  output logic [7:0]                               mem_q,
  output logic                                     active,
  output logic                                     mem_we
);
  localparam int DEPTH = ROWS * ROW_BYTES;
  localparam int AW    = $clog2(DEPTH);
  localparam int RBW   = $clog2(ROW_BYTES);

  logic [7:0]    mem [DEPTH];
  eng_st_t       st;
  logic [AW-1:0] op_addr, idx, last;
  logic [7:0]    op_data;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wd;
  logic [AW-RBW-1:0] trow;
  logic          bulk, lock_hit;

  assign trow     = tgt_addr[AW-1:RBW];
  assign bulk     = mode.erase & ~mode.sel_byte & ~mode.sel_row;
  assign lock_hit = bulk ? (|row_lock) : row_lock[trow];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ENG_IDLE;
      op_addr <= '0;
      op_data <= '0;
      idx     <= '0;
      last    <= '0;
    end else begin
      case (st)
        ENG_IDLE: if (commit && !lock_hit) begin
          op_addr <= tgt_addr;
          op_data <= tgt_data;
          if (!mode.erase) begin
            st <= ENG_RD;
          end else begin
            st <= ENG_ERS;
            if (mode.sel_byte) begin
              idx  <= tgt_addr;
              last <= tgt_addr;
            end else if (mode.sel_row) begin
              idx  <= {trow, {RBW{1'b0}}};
              last <= {trow, {RBW{1'b1}}};
            end else begin
              idx  <= '0;
              last <= AW'(DEPTH - 1);
            end
          end
        end
        ENG_RD:  st <= ENG_WR;
        ENG_WR:  st <= ENG_IDLE;
        ENG_ERS: begin
          if (idx == last) st <= ENG_IDLE;
          else             idx <= idx + AW'(1);
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  assign active = (st != ENG_IDLE);
  assign mem_we = (st == ENG_WR) || (st == ENG_ERS);

  always_comb begin
    case (st)
      ENG_IDLE: mem_addr = rd_addr;
      ENG_ERS:  mem_addr = idx;
      default:  mem_addr = op_addr;
    endcase
    mem_wd = (st == ENG_ERS) ? 8'hFF : (mem_q & op_data);
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wd;
    mem_q <= mem[mem_addr];
  end
endmodule

// File: rtl/nvm_prog_ctrl.sv
`timescale 1ns/1ps
module nvm_prog_ctrl
  import nvm_pkg::*;
#(
  parameter int unsigned BASE_ADDR   = 32'hB600,
  parameter int unsigned REG_ADDR    = 32'h103B,
  parameter int          ROWS        = 32,
  parameter int          ROW_BYTES   = 16,
  parameter int unsigned PROG_CYCLES = 20000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [15:0]     bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  output logic            bus_rvalid,
  input  logic            array_en_i,
  input  logic [ROWS-1:0] row_lock_i
);
  localparam int          DEPTH   = ROWS * ROW_BYTES;
  localparam int          AW      = $clog2(DEPTH);
  localparam int unsigned ARR_END = BASE_ADDR + DEPTH;

  logic [7:0]    ctl_q;
  logic          in_arr, reg_hit;
  logic [AW-1:0] off;
  logic [AW-1:0] cap_addr;
  logic [7:0]    cap_data;
  logic          cap_vld;
  logic          go_d, start, fire, commit;
  logic          arr_rd, eng_active, mem_we;
  logic [7:0]    mem_q;
  logic          rsel_mem, rvalid_q;
  logic [7:0]    reg_rd_q;
  op_mode_t      mode;

  assign in_arr  = (32'(bus_addr) >= BASE_ADDR) && (32'(bus_addr) < ARR_END);
  assign reg_hit = (32'(bus_addr) == REG_ADDR);
  assign off     = AW'(32'(bus_addr) - BASE_ADDR);

  nvm_ctl_reg u_ctl (
    .clk   (clk),
    .rst   (rst),
    .wr_en (bus_wr && reg_hit),
    .wdata (bus_wdata),
    .ctl_q (ctl_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_addr <= '0;
      cap_data <= '0;
      cap_vld  <= 1'b0;
      go_d     <= 1'b0;
    end else begin
      go_d <= ctl_q[CTL_GO];
      if (!ctl_q[CTL_ARM]) begin
        cap_vld <= 1'b0;
      end else if (bus_wr && in_arr && array_en_i && !ctl_q[CTL_GO]) begin
        cap_addr <= off;
        cap_data <= bus_wdata;
        cap_vld  <= 1'b1;
      end
    end
  end

  assign start = ctl_q[CTL_GO] & ~go_d;

  nvm_busy_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .go    (ctl_q[CTL_GO]),
    .fire  (fire)
  );

  assign commit = fire & ctl_q[CTL_ARM] & cap_vld;
  assign mode   = '{sel_byte: ctl_q[CTL_BYTE], sel_row: ctl_q[CTL_ROW],
                    erase: ctl_q[CTL_ERASE]};

  nvm_array_engine #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .commit   (commit),
    .mode     (mode),
    .tgt_addr (cap_addr),
    .tgt_data (cap_data),
    .row_lock (row_lock_i),
    .rd_addr  (off),
    .mem_q    (mem_q),
    .active   (eng_active),
    .mem_we   (mem_we)
  );

  assign arr_rd = bus_rd && in_arr && array_en_i && !ctl_q[CTL_ARM] && !eng_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_mem <= 1'b0;
      rvalid_q <= 1'b0;
      reg_rd_q <= '0;
    end else begin
      rsel_mem <= arr_rd;
      rvalid_q <= arr_rd || (bus_rd && reg_hit);
      reg_rd_q <= ctl_q;
    end
  end

  assign bus_rdata  = rsel_mem ? mem_q : reg_rd_q;
  assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/nvm_prog_ctrl_chk.sv
`timescale 1ns/1ps
module nvm_prog_ctrl_chk #(
  parameter int unsigned BASE_ADDR = 32'hB600,
  parameter int unsigned REG_ADDR  = 32'h103B,
  parameter int          DEPTH     = 512
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] bus_addr,
  input logic        bus_rd,
  input logic        bus_rvalid,
  input logic        array_en_i,
  input logic [7:0]  ctl_q,
  input logic        fire,
  input logic        mem_we,
  input logic        eng_active
);
  logic win;
  assign win = (32'(bus_addr) >= BASE_ADDR) && (32'(bus_addr) < BASE_ADDR + DEPTH);

  p_go_needs_arm_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_q[0]) |-> $past(ctl_q[1]));

  p_armed_no_data_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && win && ctl_q[1]) |=> !bus_rvalid);

  p_disabled_no_data_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && win && !array_en_i) |=> !bus_rvalid);

  p_fire_needs_go_r9: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(ctl_q[0]));

  p_reg_read_valid_r13: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (32'(bus_addr) == REG_ADDR)) |=> bus_rvalid);

  p_bit5_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !ctl_q[5]);

  p_write_in_op_r9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> eng_active);
endmodule

bind nvm_prog_ctrl nvm_prog_ctrl_chk #(
  .BASE_ADDR (BASE_ADDR),
  .REG_ADDR  (REG_ADDR),
  .DEPTH     (DEPTH)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_rvalid (bus_rvalid),
  .array_en_i (array_en_i),
  .ctl_q      (ctl_q),
  .fire       (fire),
  .mem_we     (mem_we),
  .eng_active (eng_active)
);

// File: tb/nvm_prog_ctrl_tb_top.sv
`timescale 1ns/1ps
module nvm_prog_ctrl_tb_top;
  localparam int          PROG  = 16;
  localparam int          ROWS  = 32;
  localparam int          DEPTH = 512;
  localparam logic [15:0] BASE  = 16'hB600;
  localparam logic [15:0] REGA  = 16'h103B;
  localparam int          W_SHORT = PROG + 12;
  localparam int          W_BULK  = PROG + 540;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst;
  logic [15:0]     bus_addr;
  logic            bus_wr, bus_rd;
  logic [7:0]      bus_wdata, bus_rdata;
  logic            bus_rvalid;
  logic            array_en_i;
  logic [ROWS-1:0] row_lock_i;

  int   n_tests = 0;
  int   n_fail  = 0;
  logic done    = 1'b0;
  logic [7:0] exp_mem [DEPTH];

  nvm_prog_ctrl #(.PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .array_en_i(array_en_i), .row_lock_i(row_lock_i)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic reg_wr(input logic [7:0] d);
    @(negedge clk); bus_addr = REGA; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic arr_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic run_op(input logic [7:0] mode, input logic [15:0] a,
                        input logic [7:0] d, input int wait_n);
    reg_wr(mode | 8'h02);
    arr_wr(a, d);
    reg_wr(mode | 8'h03);
    repeat (wait_n) @(negedge clk);
    reg_wr(8'h00);
  endtask

  task automatic chk_byte(input int i, input string tag);
    logic [7:0] d; logic v;
    rd(BASE + 16'(i), d, v);
    chk(v && d == exp_mem[i], tag, {v, d}, {1'b1, exp_mem[i]});
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < DEPTH; i++) chk_byte(i, tag);
  endtask

  task automatic chk_ctl(input logic [7:0] e, input string tag);
    logic [7:0] d; logic v;
    rd(REGA, d, v);
    chk(v && d == e, tag, {v, d}, {1'b1, e});
  endtask

  initial begin
    logic [7:0] d; logic v;
    rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    array_en_i = 1'b1; row_lock_i = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    chk_ctl(8'h00, "R1 reset value / R13 latency");

    run_op(8'h04, BASE + 16'h123, 8'h00, W_BULK);
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
    sweep("R3 bulk erase");

    for (int i = 0; i < DEPTH; i++) begin
      logic [7:0] p = 8'(i * 37 + 11);
      run_op(8'h00, BASE + 16'(i), p, W_SHORT);
      exp_mem[i] &= p;
    end
    sweep("R6 program pattern");

    run_op(8'h00, BASE + 16'h040, 8'h0F, W_SHORT); exp_mem['h40] &= 8'h0F;
    chk_byte('h40, "R6 AND clears");
    run_op(8'h00, BASE + 16'h041, 8'hFF, W_SHORT);
    chk_byte('h41, "R6 no bit set back");

    run_op(8'h0C, BASE + 16'h057, 8'h00, W_SHORT + 16);
    for (int i = 'h50; i < 'h60; i++) exp_mem[i] = 8'hFF;
    sweep("R3 R4 row erase row 5");

    run_op(8'h14, BASE + 16'h1FF, 8'h00, W_SHORT); exp_mem['h1FF] = 8'hFF;
    run_op(8'h1C, BASE + 16'h000, 8'h00, W_SHORT); exp_mem[0] = 8'hFF;
    sweep("R3 byte erase");

    run_op(8'h18, BASE + 16'h053, 8'h3C, W_SHORT); exp_mem['h53] &= 8'h3C;
    sweep("R7 program ignores select bits");

    reg_wr(8'h03); chk_ctl(8'h00, "R2 arm+go together refused");
    reg_wr(8'h01); chk_ctl(8'h00, "R2 go alone refused");
    reg_wr(8'hFF); chk_ctl(8'hDC, "R2 R1 all bits from idle");
    reg_wr(8'h00);
    reg_wr(8'h02); reg_wr(8'h03); chk_ctl(8'h03, "R2 go after arm");
    reg_wr(8'h00);

    reg_wr(8'hC0); chk_ctl(8'hC0, "R12 test bits stored");
    reg_wr(8'h00);
    run_op(8'hC0, BASE + 16'h100, 8'h77, W_SHORT); exp_mem['h100] &= 8'h77;
    chk_byte('h100, "R12 test bits no effect");

    reg_wr(8'h02);
    rd(BASE + 16'h010, d, v); chk(!v, "R5 armed read invalid", v, 0);
    arr_wr(BASE + 16'h010, 8'h00);
    reg_wr(8'h00);
    chk_byte('h10, "R5 capture write no change");

    reg_wr(8'h02); arr_wr(BASE + 16'h020, 8'h00); reg_wr(8'h03);
    repeat (6) @(negedge clk); reg_wr(8'h00);
    repeat (PROG + 8) @(negedge clk);
    chk_byte('h20, "R9 early abort");
    reg_wr(8'h02); arr_wr(BASE + 16'h020, 8'h00); reg_wr(8'h03);
    repeat (PROG + 8) @(negedge clk); reg_wr(8'h00); exp_mem['h20] = 8'h00;
    chk_byte('h20, "R9 commit after timer");

    row_lock_i = 32'h0000_0008;
    run_op(8'h00, BASE + 16'h030, 8'h00, W_SHORT);
    chk_byte('h30, "R10 locked row program");
    run_op(8'h04, BASE + 16'h1F0, 8'h00, W_BULK);
    sweep("R10 locked bulk erase");
    run_op(8'h14, BASE + 16'h045, 8'h00, W_SHORT); exp_mem['h45] = 8'hFF;
    chk_byte('h45, "R10 unlocked row erases");
    row_lock_i = '0;

    array_en_i = 1'b0;
    rd(BASE + 16'h060, d, v); chk(!v, "R8 disabled read invalid", v, 0);
    chk_ctl(8'h00, "R8 register still reachable");
    reg_wr(8'h02); arr_wr(BASE + 16'h060, 8'h00);
    array_en_i = 1'b1;
    reg_wr(8'h03); repeat (W_SHORT) @(negedge clk); reg_wr(8'h00);
    chk_byte('h60, "R8 disabled write not captured");

    rd(16'hB5FF, d, v); chk(!v, "R4 below window", v, 0);
    rd(16'hB800, d, v); chk(!v, "R4 above window", v, 0);

    reg_wr(8'h02); arr_wr(BASE + 16'h070, 8'h00); reg_wr(8'h03);
    reg_wr(8'h05); chk_ctl(8'h05, "R2 R11 go kept, arm dropped");
    chk_byte('h70, "R11 readable with go and no arm");
    repeat (W_SHORT) @(negedge clk); reg_wr(8'h00);
    chk_byte('h70, "R11 no change without arm");

    sweep("R3 R6 final contents");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule